// File: doc/BRIEF.md
# Dual H-Bridge Gate Controller with Fault Handling

This block is the digital control core for two brushed-motor H-bridges. Each bridge receives two command inputs. A global mode select picks how those two inputs are read: either each input directly commands one output, or one input sets the direction and the other switches the drive on. Every half-bridge output is driven through a high-side and a low-side gate enable. Each output can therefore be driven high, driven low, or left floating.

Several conditions can override the commands. A per-bridge overcurrent flag must persist for a set number of cycles before it shuts that bridge down, and the bridge retries on its own after a fixed interval. A global thermal flag forces every switch off for as long as it is raised. A global supply-undervoltage flag forces every switch off and clears all internal state. An active-low sleep input floats every output. The command inputs, the mode select and the sleep input are synchronized before use. A dead-time stage on each half-bridge guarantees that its two switches never conduct together.

Top module: `hbridge_ctrl`

## Requirements
- R1: With mode_sel low, bridge inputs (ctl_a, ctl_b) decode as follows: 0,0 makes both outputs floating; 1,0 makes output 1 high and output 2 low; 0,1 makes output 1 low and output 2 high; 1,1 makes both outputs low. Output 1 of bridge b is half-bridge 2b and output 2 is half-bridge 2b+1. The encodings are high = (hs_en=1, ls_en=0), low = (0,1) and floating = (0,0).
- R2: With mode_sel high, ctl_a is the phase and ctl_b is the enable. Enable 0 makes both outputs low whatever the phase. With enable 1, phase 0 makes output 1 high and output 2 low, and phase 1 makes output 1 low and output 2 high.
- R3: ctl_a, ctl_b, mode_sel and sleep_n pass through two register stages before decoding. A change in these inputs reaches the gate enables no earlier than the third rising edge after it.
- R4: hs_en and ls_en of one half-bridge are never both high. On a direct change between high and low, both enables of that half-bridge are low for exactly DEAD_CYCLES cycles before the new switch turns on.
- R5: A bridge trips once its oc_flag has been sampled high on OC_QUAL_CYCLES consecutive rising edges, and oc_fault for that bridge rises after that edge. If oc_flag drops earlier, the persistence count restarts from zero.
- R6: While a bridge's oc_fault is high, all four of its gate enables are low and the other bridge keeps following its commands. oc_fault stays high for exactly RETRY_CYCLES cycles, after which the bridge resumes on its own.
- R7: While therm_flag is high, every gate enable is low from the next rising edge. When it clears, the outputs return to the commanded state without further action.
- R8: While uv_flag is high, every gate enable and every oc_fault is low from the next rising edge. Persistence and retry counters and the input synchronizers are cleared, so after uv_flag drops the outputs stay off until fresh inputs have crossed the synchronizer.
- R9: While the synchronized sleep_n is low, every gate enable is low regardless of the commands.
- R10: sys_fault equals therm_flag OR uv_flag in the same cycle. After reset, all gate enables, oc_fault and sys_fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | 0: direct per-output decoding, 1: phase/enable decoding |
| sleep_n | input | 1 | Sleep request, active low; floats all outputs |
| ctl_a | input | NUM_BRIDGES | First command input per bridge (phase in mode 1) |
| ctl_b | input | NUM_BRIDGES | Second command input per bridge (enable in mode 1) |
| oc_flag | input | NUM_BRIDGES | Overcurrent comparator flag per bridge |
| therm_flag | input | 1 | Over-temperature flag |
| uv_flag | input | 1 | Supply undervoltage flag |
| hs_en | output | 2*NUM_BRIDGES | High-side gate enable per half-bridge |
| ls_en | output | 2*NUM_BRIDGES | Low-side gate enable per half-bridge |
| oc_fault | output | NUM_BRIDGES | Overcurrent shutdown active per bridge |
| sys_fault | output | 1 | Thermal or undervoltage condition present |

## Verification
The bench builds the block with two bridges, a dead time of 2 cycles, a qualification time of 4 cycles and a retry interval of 20 cycles. These short windows let one run sweep all 16 input combinations of both bridges under both decodings. They also make it possible to count the dead-time gap, the qualification threshold and the retry interval cycle by cycle. The same settings put the undervoltage clearing of a half-full persistence count, and of the synchronizers, within a few cycles of observation.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    typedef enum logic [1:0] {
        HB_OFF  = 2'b00,
        HB_LOW  = 2'b01,
        HB_HIGH = 2'b10
    } hb_cmd_e;

    typedef struct packed {
        hb_cmd_e out1;
        hb_cmd_e out2;
    } hb_pair_t;

    function automatic hb_pair_t hbr_decode(input logic phase_mode,
                                            input logic a,
                                            input logic b);
        hb_pair_t r;
        if (phase_mode) begin
            if (!b) begin
                r.out1 = HB_LOW;
                r.out2 = HB_LOW;
            end else if (a) begin
                r.out1 = HB_LOW;
                r.out2 = HB_HIGH;
            end else begin
                r.out1 = HB_HIGH;
                r.out2 = HB_LOW;
            end
        end else begin
            unique case ({a, b})
                2'b00:   begin r.out1 = HB_OFF;  r.out2 = HB_OFF;  end
                2'b10:   begin r.out1 = HB_HIGH; r.out2 = HB_LOW;  end
                2'b01:   begin r.out1 = HB_LOW;  r.out2 = HB_HIGH; end
                default: begin r.out1 = HB_LOW;  r.out2 = HB_LOW;  end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
        if (clr_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/hbr_ocp.sv
module hbr_ocp #(
    parameter int QUAL_CYCLES  = 64,
    parameter int RETRY_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic oc_i,
    output logic fault_o
);

    localparam int MAXC = (QUAL_CYCLES > RETRY_CYCLES) ? QUAL_CYCLES : RETRY_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic          shut;
        logic [CW-1:0] cnt;
    } ocp_st_t;

    ocp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.shut) begin
            if (oc_i) begin
                if (st_q.cnt == CW'(QUAL_CYCLES - 1)) begin
                    st_d.shut = 1'b1;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end else begin
            if (st_q.cnt == CW'(RETRY_CYCLES - 1)) begin
                st_d.shut = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (clr_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_o = st_q.shut;

    // A trip needs the flag present on the qualifying edge
    assert_trip_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.shut) |-> $past(oc_i));

    // Undervoltage leaves no shutdown or partial count behind
    assert_uv_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!st_q.shut && st_q.cnt == '0));

endmodule

// File: rtl/hbr_deadtime.sv
module hbr_deadtime
    import hbr_pkg::*;
#(
    parameter int DEAD_CYCLES = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr_i,
    input  hb_cmd_e tgt_i,
    output logic    hs_o,
    output logic    ls_o
);

    localparam int DW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;

    typedef struct packed {
        logic          hs;
        logic          ls;
        logic [DW-1:0] dt;
    } dt_st_t;

    dt_st_t st_d, st_q;
    logic   all_off;

    always_comb begin
        st_d    = st_q;
        all_off = !st_q.hs && !st_q.ls;
        if (!all_off) begin
            if (tgt_i == HB_OFF ||
                (tgt_i == HB_HIGH && st_q.ls) ||
                (tgt_i == HB_LOW  && st_q.hs)) begin
                st_d.hs = 1'b0;
                st_d.ls = 1'b0;
                st_d.dt = '0;
            end
        end else if (st_q.dt == DW'(DEAD_CYCLES - 1)) begin
            st_d.hs = (tgt_i == HB_HIGH);
            st_d.ls = (tgt_i == HB_LOW);
        end else begin
            st_d.dt = st_q.dt + 1'b1;
        end
        if (clr_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_o = st_q.hs;
    assign ls_o = st_q.ls;

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hs && st_q.ls));

    assert_hs_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hs) |-> $past(!st_q.ls));

    assert_ls_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ls) |-> $past(!st_q.hs));

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hbr_pkg::*;
#(
    parameter int NUM_BRIDGES    = 2,
    parameter int DEAD_CYCLES    = 4,
    parameter int OC_QUAL_CYCLES = 64,
    parameter int RETRY_CYCLES   = 50000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_sel,
    input  logic                     sleep_n,
    input  logic [NUM_BRIDGES-1:0]   ctl_a,
    input  logic [NUM_BRIDGES-1:0]   ctl_b,
    input  logic [NUM_BRIDGES-1:0]   oc_flag,
    input  logic                     therm_flag,
    input  logic                     uv_flag,
    output logic [2*NUM_BRIDGES-1:0] hs_en,
    output logic [2*NUM_BRIDGES-1:0] ls_en,
    output logic [NUM_BRIDGES-1:0]   oc_fault,
    output logic                     sys_fault
);

    localparam int NB = NUM_BRIDGES;
    localparam int SW = 2 * NB + 2;

    logic [SW-1:0] sync_q;
    logic [NB-1:0] s_ctl_a, s_ctl_b;
    logic          s_mode, s_awake;

    hbr_sync #(.WIDTH(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (uv_flag),
        .d_i   ({sleep_n, mode_sel, ctl_b, ctl_a}),
        .q_o   (sync_q)
    );

    assign s_ctl_a = sync_q[NB-1:0];
    assign s_ctl_b = sync_q[2*NB-1:NB];
    assign s_mode  = sync_q[2*NB];
    assign s_awake = sync_q[2*NB+1];

    for (genvar b = 0; b < NB; b++) begin : g_bridge
        hb_pair_t cmd_w;
        hb_cmd_e  tgt1_w, tgt2_w;
        logic     hold_w;

        hbr_ocp #(
            .QUAL_CYCLES  (OC_QUAL_CYCLES),
            .RETRY_CYCLES (RETRY_CYCLES)
        ) u_ocp (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (uv_flag),
            .oc_i    (oc_flag[b]),
            .fault_o (oc_fault[b])
        );

        always_comb begin
            cmd_w  = hbr_decode(s_mode, s_ctl_a[b], s_ctl_b[b]);
            hold_w = !s_awake || therm_flag || oc_fault[b];
            tgt1_w = hold_w ? HB_OFF : cmd_w.out1;
            tgt2_w = hold_w ? HB_OFF : cmd_w.out2;
        end

        hbr_deadtime #(.DEAD_CYCLES(DEAD_CYCLES)) u_dt1 (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (uv_flag),
            .tgt_i (tgt1_w),
            .hs_o  (hs_en[2*b]),
            .ls_o  (ls_en[2*b])
        );

        hbr_deadtime #(.DEAD_CYCLES(DEAD_CYCLES)) u_dt2 (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (uv_flag),
            .tgt_i (tgt2_w),
            .hs_o  (hs_en[2*b+1]),
            .ls_o  (ls_en[2*b+1])
        );

        assert_oc_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            oc_fault[b] |=> (hs_en[2*b+1:2*b] == 2'b00 && ls_en[2*b+1:2*b] == 2'b00));
    end

    assign sys_fault = therm_flag | uv_flag;

    assert_therm_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        therm_flag |=> (hs_en == '0 && ls_en == '0));

    assert_uv_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (hs_en == '0 && ls_en == '0 && oc_fault == '0));

endmodule

// File: tb/sim_hbridge_ctrl.sv
module sim_hbridge_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEAD  = 2;
    localparam int QUAL  = 4;
    localparam int RETRY = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic       sleep_n = 1'b1;
    logic [1:0] ctl_a = '0, ctl_b = '0, oc_flag = '0;
    logic       therm_flag = 1'b0, uv_flag = 1'b0;
    logic [3:0] hs_en, ls_en;
    logic [1:0] oc_fault;
    logic       sys_fault;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbridge_ctrl #(
        .NUM_BRIDGES    (2),
        .DEAD_CYCLES    (DEAD),
        .OC_QUAL_CYCLES (QUAL),
        .RETRY_CYCLES   (RETRY)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_n(sleep_n),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .oc_flag(oc_flag),
        .therm_flag(therm_flag), .uv_flag(uv_flag),
        .hs_en(hs_en), .ls_en(ls_en), .oc_fault(oc_fault), .sys_fault(sys_fault)
    );

    // {hs,ls}: high 10, low 01, floating 00
    function automatic logic [1:0] exp_half(input logic m, input logic a,
                                            input logic b, input logic second);
        if (m) begin
            if (!b) return 2'b01;
            return (a ^ second) ? 2'b01 : 2'b10;
        end
        if (!a && !b) return 2'b00;
        if (a && b)   return 2'b01;
        return ((second ? b : a) == 1'b1) ? 2'b10 : 2'b01;
    endfunction

    // Returns {hs[3:0], ls[3:0]}
    function automatic logic [7:0] exp_all(input logic m, input logic [1:0] a,
                                           input logic [1:0] b);
        logic [3:0] h, l;
        logic [1:0] p;
        for (int br = 0; br < 2; br++) begin
            for (int s = 0; s < 2; s++) begin
                p = exp_half(m, a[br], b[br], s[0]);
                h[2*br+s] = p[1];
                l[2*br+s] = p[0];
            end
        end
        return {h, l};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_out(input string req, input string what, input logic [7:0] exp);
        check({hs_en, ls_en} === exp, req, what, {24'h0, hs_en, ls_en}, {24'h0, exp});
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cnt;
        step(3);
        check_out("R10", "outputs in reset", 8'h00);
        check(oc_fault === 2'b00 && sys_fault === 1'b0, "R10", "status in reset",
              {29'h0, oc_fault, sys_fault}, 32'h0);
        rst_n = 1'b1;
        step(2);

        // Exhaustive decode sweep under both modes
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 16; c++) begin
                mode_sel = m[0];
                ctl_a = {c[2], c[0]};
                ctl_b = {c[3], c[1]};
                step(8);
                check_out(m ? "R2" : "R1", "decode", exp_all(mode_sel, ctl_a, ctl_b));
            end
        end

        // Latency and dead time: bridge0 forward -> reverse, bridge1 forward
        mode_sel = 1'b0; ctl_a = 2'b11; ctl_b = 2'b00;
        step(8);
        check_out("R1", "both forward", exp_all(0, 2'b11, 2'b00));
        ctl_a = 2'b10; ctl_b = 2'b01;
        step(2);
        check_out("R3", "unchanged after two edges", exp_all(0, 2'b11, 2'b00));
        step(1);
        check_out("R4", "gap cycle 1", exp_all(0, 2'b10, 2'b01) & 8'b1100_1100);
        step(1);
        check_out("R4", "gap cycle 2", exp_all(0, 2'b10, 2'b01) & 8'b1100_1100);
        step(1);
        check_out("R4", "new direction after gap", exp_all(0, 2'b10, 2'b01));

        // Overcurrent shorter than the qualification time
        oc_flag = 2'b01;
        step(QUAL - 1);
        oc_flag = 2'b00;
        step(2);
        check(oc_fault === 2'b00, "R5", "short pulse no trip", {30'h0, oc_fault}, 0);
        check_out("R5", "outputs kept", exp_all(0, 2'b10, 2'b01));

        // Qualified overcurrent on bridge0
        oc_flag = 2'b01;
        step(QUAL - 1);
        check(oc_fault === 2'b00, "R5", "no trip before threshold", {30'h0, oc_fault}, 0);
        step(1);
        check(oc_fault === 2'b01, "R5", "trip at threshold", {30'h0, oc_fault}, 1);
        oc_flag = 2'b00;
        cnt = 1;
        step(1);
        check_out("R6", "bridge0 off, bridge1 runs", exp_all(0, 2'b10, 2'b01) & 8'b1100_1100);
        if (oc_fault[0]) cnt++;
        for (int i = 0; i < 4 * RETRY; i++) begin
            step(1);
            if (oc_fault[0]) cnt++;
            else break;
        end
        check(cnt == RETRY, "R6", "retry interval", cnt, RETRY);
        step(3);
        check_out("R6", "bridge0 resumed", exp_all(0, 2'b10, 2'b01));

        // Undervoltage clears partial count and synchronizers
        oc_flag = 2'b01;
        step(QUAL - 1);
        uv_flag = 1'b1;
        #1;
        check(sys_fault === 1'b1, "R10", "sys_fault on uv", sys_fault, 1);
        step(1);
        check_out("R8", "outputs off under uv", 8'h00);
        check(oc_fault === 2'b00, "R8", "no fault under uv", {30'h0, oc_fault}, 0);
        uv_flag = 1'b0;
        step(1);
        check_out("R8", "still off, syncs cleared", 8'h00);
        step(2);
        check_out("R8", "restart after uv", exp_all(0, 2'b10, 2'b01));
        check(oc_fault === 2'b00, "R8", "count was restarted", {30'h0, oc_fault}, 0);
        oc_flag = 2'b00;
        step(3);
        check(oc_fault === 2'b00, "R5", "no late trip", {30'h0, oc_fault}, 0);

        // Thermal fault
        therm_flag = 1'b1;
        #1;
        check(sys_fault === 1'b1, "R10", "sys_fault on thermal", sys_fault, 1);
        step(1);
        check_out("R7", "off under thermal", 8'h00);
        ctl_a = 2'b00; ctl_b = 2'b10;
        step(5);
        check_out("R7", "commands held off", 8'h00);
        therm_flag = 1'b0;
        #1;
        check(sys_fault === 1'b0, "R10", "sys_fault clears", sys_fault, 0);
        step(4);
        check_out("R7", "resume after thermal", exp_all(0, 2'b00, 2'b10));

        // Sleep, in phase/enable mode
        mode_sel = 1'b1; ctl_a = 2'b01; ctl_b = 2'b11;
        step(8);
        check_out("R2", "phase/enable running", exp_all(1, 2'b01, 2'b11));
        sleep_n = 1'b0;
        step(3);
        check_out("R9", "sleep floats outputs", 8'h00);
        ctl_b = 2'b00;
        step(5);
        check_out("R9", "sleep ignores commands", 8'h00);
        sleep_n = 1'b1;
        step(6);
        check_out("R9", "wake resumes", exp_all(1, 2'b01, 2'b00));

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule